// File: doc/BRIEF.md
# Transpose-Network Next-Hop Router

This block decides, one hop at a time, how a packet moves through a two-level network. The network is built from groups of processors. A processor is named by a pair of binary labels: the label of its group and the label of the node inside that group. Two kinds of link exist. An electronic link joins two processors of one group whose node labels differ in exactly one bit. An optical link joins processor (u, v) to processor (v, u), so crossing it swaps the two labels.

For each packet position, the caller presents the current address, the destination address and a valid strobe. One cycle later the block returns one decision: flip one node-label bit, take the optical hop, or deliver. The caller applies the hop and presents the new address on the next request.

The route has three stages. First the node label is corrected until it equals the destination group label. Then one optical hop crosses to the destination group. Then the node label is corrected until it equals the destination node label. When the source is already in the destination group, only the last stage is used. A mode input picks whether differing bits are corrected from the low end or from the high end. Node codes whose two low bits are both 1 are not used, and the picker never steps onto one. A hop counter reports the length of the current path.

Top module: `otis_next_hop`

## Requirements
- R1: `out_valid` is `in_valid` delayed by one clock. A decision is registered on the clock edge where `in_valid` is high, and it is held while `in_valid` is low.
- R2: When the current group and node labels both equal the destination labels, the decision is DELIVER.
- R3: When the current group equals the destination group but the node labels differ, the decision is ELECTRIC and flips a bit toward the destination node label. It is never OPTICAL.
- R4: When the groups differ and the current node label differs from the destination group label, the decision is ELECTRIC and flips a bit toward the destination group label.
- R5: When the groups differ and the current node label equals the destination group label, the decision is OPTICAL.
- R6: With `scan_msb_first` = 0, the flipped bit is the lowest differing bit. With `scan_msb_first` = 1, it is the highest differing bit. R7 overrides this rule.
- R7: Node codes with bits [1:0] = 2'b11 are unused. If flipping the bit chosen by R6 would produce such a code, the other bit of the pair [1:0] is flipped instead.
- R8: `out_kind` is encoded as 0 = DELIVER, 1 = ELECTRIC, 2 = OPTICAL. `out_bit` carries the node-label bit index for ELECTRIC and is 0 otherwise.
- R9: `hop_count` adds 1 for each registered ELECTRIC or OPTICAL decision. After a DELIVER it holds the length of the path just completed. The next decision starts counting again from 0.
- R10: Following the decisions from any valid source to any valid destination reaches DELIVER within 2·DH+3 hops. With DH = 2, the route from (000,000) to (110,110) takes four ELECTRIC hops and one OPTICAL hop in either scan order.
- R11: While reset is asserted, `out_valid` is 0 and `hop_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe for a decision |
| scan_msb_first | input | 1 | Scan order: 0 = low bit first, 1 = high bit first |
| cur_group | input | DH+1 | Group label of the current processor |
| cur_node | input | DH+1 | Node label of the current processor |
| dst_group | input | DH+1 | Group label of the destination |
| dst_node | input | DH+1 | Node label of the destination |
| out_valid | output | 1 | Decision valid |
| out_kind | output | 2 | Decision kind (R8 encoding) |
| out_bit | output | clog2(DH+1) | Bit index for an ELECTRIC hop |
| hop_count | output | clog2(2·DH+4)+1 | Hops counted on the current path |

## Verification
Several rules are checked by properties on every cycle. The strobe latency is checked, and so are the deliver, optical and no-optical-in-group rules. The picker always chooses a bit that really differs, and it never lands on an unused code. The counter steps by one within a path and restarts after delivery. Some behaviour can only be shown by the bench's scenarios, which walk every valid source and destination pair in both scan orders. These scenarios show the exact bit order, the bound on path length, the five-hop example, and the hop total left on the counter after delivery.

// File: rtl/otis_route_pkg.sv
package otis_route_pkg;
   typedef enum logic [1:0] {
      K_DELIVER  = 2'd0,
      K_ELECTRIC = 2'd1,
      K_OPTICAL  = 2'd2
   } hop_kind_e;
endpackage

// File: rtl/otis_bit_picker.sv
module otis_bit_picker #(
   parameter int W  = 3,
   localparam int IW = $clog2(W)
) (
   input  logic [W-1:0]  cur,
   input  logic [W-1:0]  tgt,
   input  logic          msb_first,
   output logic          has_diff,
   output logic [IW-1:0] idx
);
   logic [W-1:0]  diff;
   logic [IW-1:0] lo_idx, hi_idx, first;
   logic          lo_found;
   logic [W-1:0]  trial;

   always_comb begin
      diff     = cur ^ tgt;
      lo_idx   = '0;
      hi_idx   = '0;
      lo_found = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (diff[i] && !lo_found) begin
            lo_idx   = IW'(i);
            lo_found = 1'b1;
         end
         if (diff[i]) hi_idx = IW'(i);
      end
      has_diff = |diff;
      first    = msb_first ? hi_idx : lo_idx;
      trial    = cur ^ (W'(1) << first);
      // unused node codes end in 2'b11: steer to the other low bit
      if (trial[1:0] == 2'b11)
         idx = (first == '0) ? IW'(1) : IW'(0);
      else
         idx = first;
   end

   logic [W-1:0] landed;
   always_comb begin
      landed = cur ^ (W'(1) << idx);
      // R6: the chosen bit is always one that differs
      a_r6_bit_differs: assert (!has_diff || diff[idx]);
      // R7: from a used code toward a used code, never land on an unused one
      a_r7_guard: assert (!(has_diff && cur[1:0] != 2'b11 && tgt[1:0] != 2'b11)
                          || landed[1:0] != 2'b11);
   end
endmodule

// File: rtl/otis_hop_tally.sv
module otis_hop_tally #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          is_hop,
   input  logic          is_end,
   output logic [CW-1:0] count
);
   logic          fresh;
   logic [CW-1:0] base;

   always_comb base = fresh ? '0 : count;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         fresh <= 1'b1;
      end else if (step) begin
         if (is_hop && base != '1) count <= base + 1'b1;
         else                      count <= base;
         fresh <= is_end;
      end
   end

   a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !fresh && is_hop && count != '1) |=> count == $past(count) + 1'b1);
   a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (step && fresh) |=> count <= CW'(1));
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(count));
endmodule

// File: rtl/otis_next_hop.sv
module otis_next_hop
   import otis_route_pkg::*;
#(
   parameter int DH = 2,
   localparam int W    = DH + 1,
   localparam int IW   = $clog2(W),
   localparam int MAXH = 2 * DH + 3,
   localparam int CW   = $clog2(MAXH + 1) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          scan_msb_first,
   input  logic [W-1:0]  cur_group,
   input  logic [W-1:0]  cur_node,
   input  logic [W-1:0]  dst_group,
   input  logic [W-1:0]  dst_node,
   output logic          out_valid,
   output logic [1:0]    out_kind,
   output logic [IW-1:0] out_bit,
   output logic [CW-1:0] hop_count
);
   generate
      if (DH < 1) begin : g_bad_dh
         $error("otis_next_hop: DH must be at least 1");
      end
   endgenerate

   logic          same_grp, at_dst, need_opt, has_diff;
   logic [W-1:0]  fix_tgt;
   logic [IW-1:0] pick_idx;
   hop_kind_e     nxt_kind;
   logic [IW-1:0] nxt_bit;

   always_comb begin
      same_grp = (cur_group == dst_group);
      at_dst   = same_grp && (cur_node == dst_node);
      need_opt = !same_grp && (cur_node == dst_group);
      fix_tgt  = same_grp ? dst_node : dst_group;
   end

   otis_bit_picker #(.W(W)) u_pick (
      .cur       (cur_node),
      .tgt       (fix_tgt),
      .msb_first (scan_msb_first),
      .has_diff  (has_diff),
      .idx       (pick_idx)
   );

   always_comb begin
      nxt_bit = '0;
      if (at_dst)        nxt_kind = K_DELIVER;
      else if (need_opt) nxt_kind = K_OPTICAL;
      else begin
         nxt_kind = K_ELECTRIC;
         nxt_bit  = pick_idx;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_kind  <= K_DELIVER;
         out_bit   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_kind <= nxt_kind;
            out_bit  <= nxt_bit;
         end
      end
   end

   otis_hop_tally #(.CW(CW)) u_tally (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (in_valid),
      .is_hop (nxt_kind != K_DELIVER),
      .is_end (nxt_kind == K_DELIVER),
      .count  (hop_count)
   );

   a_r1_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r2_deliver: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cur_group == dst_group && cur_node == dst_node)
      |=> out_kind == K_DELIVER);
   a_r3_no_optical_in_group: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cur_group == dst_group) |=> out_kind != K_OPTICAL);
   a_r5_optical: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cur_group != dst_group && cur_node == dst_group)
      |=> out_kind == K_OPTICAL);
   a_r8_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind != K_ELECTRIC) |-> out_bit == '0);
endmodule

// File: tb/otis_next_hop_test.sv
`timescale 1ns/1ps
module otis_next_hop_test;
   localparam int DH   = 2;
   localparam int W    = DH + 1;
   localparam int IW   = $clog2(W);
   localparam int MAXH = 2 * DH + 3;
   localparam int CW   = $clog2(MAXH + 1) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          scan_msb_first = 1'b0;
   logic [W-1:0]  cur_group = '0, cur_node = '0, dst_group = '0, dst_node = '0;
   logic          out_valid;
   logic [1:0]    out_kind;
   logic [IW-1:0] out_bit;
   logic [CW-1:0] hop_count;

   int checks = 0;
   int errors = 0;
   int exp_hops = 0;
   bit exp_fresh = 1'b1;
   int last_kind, last_bit;

   always #5 clk = ~clk;

   otis_next_hop #(.DH(DH)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .scan_msb_first(scan_msb_first),
      .cur_group(cur_group), .cur_node(cur_node), .dst_group(dst_group), .dst_node(dst_node),
      .out_valid(out_valid), .out_kind(out_kind), .out_bit(out_bit), .hop_count(hop_count)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit unused(input int code);
      return (code & 3) == 3;
   endfunction

   // behavioural reference: candidate bits in scan order, first one landing on a used code
   function automatic int ref_bit(input int c, input int t, input bit msb);
      int order[$];
      for (int k = 0; k < W; k++) begin
         int pos = msb ? (W - 1 - k) : k;
         if (((c >> pos) & 1) != ((t >> pos) & 1)) order.push_back(pos);
      end
      foreach (order[j]) if (!unused(c ^ (1 << order[j]))) return order[j];
      return (order.size() > 0) ? order[0] : 0;
   endfunction

   // one decision: drive at a falling edge, compare at the next falling edge
   task automatic step(input int g, input int n, input int dg, input int dn,
                       input bit msb, input string tag);
      int ek, eb;
      cur_group = W'(g); cur_node = W'(n); dst_group = W'(dg); dst_node = W'(dn);
      scan_msb_first = msb; in_valid = 1'b1;
      eb = 0;
      if (g == dg && n == dn)  ek = 0;
      else if (g == dg)        begin ek = 1; eb = ref_bit(n, dn, msb); end
      else if (n == dg)        ek = 2;
      else                     begin ek = 1; eb = ref_bit(n, dg, msb); end
      if (exp_fresh) exp_hops = 0;
      if (ek != 0) exp_hops++;
      exp_fresh = (ek == 0);
      @(negedge clk);
      chk({tag, " R1 out_valid"}, int'(out_valid), 1);
      chk({tag, " R2/R3/R4/R5/R8 kind"}, int'(out_kind), ek);
      chk({tag, " R6/R7/R8 bit"}, int'(out_bit), eb);
      chk({tag, " R9 hop_count"}, int'(hop_count), exp_hops);
      last_kind = ek; last_bit = eb;
   endtask

   task automatic walk(input int sg, input int sn, input int dg, input int dn,
                       input bit msb, output int hops, output int elec);
      int g = sg, n = sn;
      hops = 0; elec = 0;
      for (int s = 0; s < 4 * W + 4; s++) begin
         step(g, n, dg, dn, msb, "walk");
         if (last_kind == 0) break;
         hops++;
         if (last_kind == 1) begin
            n = n ^ (1 << last_bit);
            elec++;
            chk("R7 landed on used code", int'(unused(n)), 0);
         end else begin
            int tmp = g; g = n; n = tmp;
         end
      end
      chk("R10 reached deliver", last_kind, 0);
      chk("R10 within bound", int'(hops <= MAXH), 1);
      chk("R9 total held after deliver", int'(hop_count), hops);
   endtask

   initial begin
      #2_000_000;
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int h, e;
      repeat (3) @(negedge clk);
      chk("R11 out_valid in reset", int'(out_valid), 0);
      chk("R11 hop_count in reset", int'(hop_count), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: the five-hop example in both scan orders
      for (int m = 0; m < 2; m++) begin
         walk(0, 0, 6, 6, m[0], h, e);
         chk("R10 example hops", h, 5);
         chk("R10 example electric hops", e, 4);
      end

      // R7: guard steers away from codes ending in 2'b11
      step(0, 1, 2, 0, 1'b1, "R7 msb");
      chk("R7 msb picks bit0", last_bit, 0);
      step(0, 0, 2, 0, 1'b0, "flush");
      step(2, 0, 2, 0, 1'b0, "flush");
      step(0, 2, 1, 0, 1'b0, "R7 lsb");
      chk("R7 lsb picks bit1", last_bit, 1);
      step(1, 0, 1, 0, 1'b0, "flush");

      // R3: same group never optical
      step(5, 0, 5, 4, 1'b0, "R3");
      chk("R3 electric bit2", last_bit, 2);
      step(5, 4, 5, 4, 1'b0, "R2");

      // R1: idle strobe drops out_valid, counter holds
      in_valid = 1'b0;
      @(negedge clk);
      chk("R1 out_valid low when idle", int'(out_valid), 0);
      chk("R9 hop_count held when idle", int'(hop_count), exp_hops);

      // exhaustive walks over used codes, both scan orders
      for (int m = 0; m < 2; m++)
         for (int sg = 0; sg < (1 << W); sg++)
            for (int sn = 0; sn < (1 << W); sn++)
               for (int dg = 0; dg < (1 << W); dg++)
                  for (int dn = 0; dn < (1 << W); dn++)
                     if (!unused(sg) && !unused(sn) && !unused(dg) && !unused(dn))
                        walk(sg, sn, dg, dn, m[0], h, e);

      in_valid = 1'b0;
      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule